// File: doc/BRIEF.md
# NAND Flash Bus Command/Address Front End

This block sits on the device side of a NAND flash bus. It watches the write strobe and, on each rising edge of that strobe, samples the I/O bus while the device is selected. Two latch-select inputs decide what the sample is. If only the command select is high, the sample is a command byte. If only the address select is high, it is an address byte. If neither is high, it is a data word. If both are high, the sample is a protocol error. Each kind of sample has its own output port and its own one-clock valid pulse, so the command decoder, the address assembler and the page buffer behind this block never have to sort the bus themselves.

The write strobe is treated as an asynchronous pin. It passes through a synchronizer on the system clock before its edge is detected. The latch selects, the bus and the selection state pass through a delay line of the same depth, so the values reported are the ones present when the strobe was first sampled high.

The block also holds the chip-selection state. When chip enable rises while the busy flag is set, the device stays selected until busy clears. The block drives the read-data bus through an output value and a separate tri-state enable. A parameter picks a bus width of 8 or 16 bits.

Top module: `nand_front_end`

## Requirements
- R1: A write-strobe rising edge produces no pulse of any kind while the device is deselected, that is, while `selected_o` is 0.
- R2: When `cmd_en_i`=1 and `addr_en_i`=0 at a captured edge, `cmd_valid_o` pulses and `cmd_o` equals `io_i[7:0]`.
- R3: When `cmd_en_i`=0 and `addr_en_i`=1 at a captured edge, `addr_valid_o` pulses and `addr_o` equals `io_i[7:0]`.
- R4: When both latch selects are 0 at a captured edge, `data_valid_o` pulses. `data_o` equals `io_i` in 16-bit mode (`WIDE_BUS`=1). In 8-bit mode (`WIDE_BUS`=0), `data_o` is `{8'h00, io_i[7:0]}`, and bits 15:8 of `data_o` are always 0.
- R5: In 16-bit mode, commands and addresses take only `io_i[7:0]`. Bits 15:8 of the bus have no effect on `cmd_o` or `addr_o`.
- R6: When both latch selects are 1 at a captured edge, `proto_err_o` pulses and none of the command, address or data valid outputs is asserted.
- R7: Each valid pulse and each error pulse lasts exactly one clock. At most one of the four is high in any cycle.
- R8: Chip enable is active low. `selected_o` becomes 1 one clock after `ce_ni`=0 is sampled. It becomes 0 one clock after `ce_ni`=1 is sampled with `busy_i`=0. After reset it is 0.
- R9: If `ce_ni` rises while the device is selected and `busy_i`=1, `selected_o` stays 1 and writes are still captured. It drops one clock after `busy_i` is sampled at 0.
- R10: `io_oe_o` is 1 only while `selected_o`=1 and `oe_ni`=0. `oe_ni` acts on it combinationally. While it is 1, `io_o` equals `rd_data_i`; otherwise `io_o` is all zeros.
- R11: With `SYNC_STAGES`=2, a valid pulse is high in the clock cycle that follows the third rising clock edge at which `we_i` is high. The first such edge is counted as one. The bus and latch selects must be valid at that first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_i | input | 1 | Write strobe, asynchronous, captured on its rising edge |
| cmd_en_i | input | 1 | Command latch select |
| addr_en_i | input | 1 | Address latch select |
| busy_i | input | 1 | Array busy flag |
| io_i | input | BUS_W | I/O bus as seen at the pins |
| rd_data_i | input | BUS_W | Read data from the array side |
| io_o | output | BUS_W | Read data driven to the pins |
| io_oe_o | output | 1 | Tri-state enable for io_o |
| selected_o | output | 1 | Device selection state |
| cmd_valid_o | output | 1 | Command byte pulse |
| cmd_o | output | 8 | Captured command byte |
| addr_valid_o | output | 1 | Address byte pulse |
| addr_o | output | 8 | Captured address byte |
| data_valid_o | output | 1 | Data word pulse |
| data_o | output | 16 | Captured data word, zero-extended in 8-bit mode |
| proto_err_o | output | 1 | Both latch selects high at a captured edge |

## Verification
The hardest state to reach from the ports is the busy hold. Here chip enable is already high, yet the device must still count as selected and must still accept writes. The stimulus selects the device, raises busy and then raises chip enable. It checks that `selected_o` holds, issues a command write during the hold, and then drops busy to see the deselect one clock later. The exact pulse latency is also checked by sampling the command pulse on the cycles before, at and after the expected clock. A second instance in 8-bit mode shares the stimulus so that the zero extension of data words can be checked.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [2:0] {
    CAP_NONE,
    CAP_CMD,
    CAP_ADDR,
    CAP_DATA,
    CAP_ERR
  } cap_kind_e;

  function automatic cap_kind_e classify(input logic cle, input logic ale);
    unique case ({cle, ale})
      2'b10:   return CAP_CMD;
      2'b01:   return CAP_ADDR;
      2'b00:   return CAP_DATA;
      default: return CAP_ERR;
    endcase
  endfunction
endpackage

// File: rtl/nand_fe_strobe_sync.sv
module nand_fe_strobe_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned PW     = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [PW-1:0] payload_i,
  output logic          rise_o,
  output logic [PW-1:0] payload_o
);
  // strobe shift: [STAGES-1] is the synced level, [STAGES] the previous one
  logic [STAGES:0] sh_q;
  logic [PW-1:0]   pl_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  // payload delayed by the same depth as the synced strobe level
  for (genvar i = 0; i < STAGES; i++) begin : g_pl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pl_q[i] <= '0;
      else if (i == 0) pl_q[i] <= payload_i;
      else             pl_q[i] <= pl_q[(i == 0) ? 0 : i-1];
    end
  end

  assign rise_o    = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign payload_o = pl_q[STAGES-1];
endmodule

// File: rtl/nand_fe_select.sv
module nand_fe_select (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic busy_i,
  output logic sel_o
);
  logic sel_q;

  // busy holds an existing selection against a chip-enable release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= ~ce_ni | (sel_q & busy_i);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/nand_fe_capture.sv
module nand_fe_capture
  import nand_fe_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              sel_i,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              addr_valid_o,
  output logic [CMD_W-1:0]  addr_o,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic [DATA_W-1:0] data_ext;
  cap_kind_e         kind;

  if (BUS_W >= DATA_W) begin : g_full
    assign data_ext = bus_i[DATA_W-1:0];
  end else begin : g_ext
    assign data_ext = {{(DATA_W-BUS_W){1'b0}}, bus_i};
  end

  always_comb begin
    kind = CAP_NONE;
    if (rise_i && sel_i) kind = classify(cle_i, ale_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o  <= 1'b0;
      addr_valid_o <= 1'b0;
      data_valid_o <= 1'b0;
      err_o        <= 1'b0;
      cmd_o        <= '0;
      addr_o       <= '0;
      data_o       <= '0;
    end else begin
      cmd_valid_o  <= (kind == CAP_CMD);
      addr_valid_o <= (kind == CAP_ADDR);
      data_valid_o <= (kind == CAP_DATA);
      err_o        <= (kind == CAP_ERR);
      if (kind == CAP_CMD)  cmd_o  <= bus_i[CMD_W-1:0];
      if (kind == CAP_ADDR) addr_o <= bus_i[CMD_W-1:0];
      if (kind == CAP_DATA) data_o <= data_ext;
    end
  end
endmodule

// File: rtl/nand_fe_out_drv.sv
module nand_fe_out_drv #(
  parameter int unsigned BUS_W = 16
) (
  input  logic             sel_i,
  input  logic             oe_ni,
  input  logic [BUS_W-1:0] rd_data_i,
  output logic [BUS_W-1:0] io_o,
  output logic             io_oe_o
);
  assign io_oe_o = sel_i & ~oe_ni;
  assign io_o    = io_oe_o ? rd_data_i : '0;
endmodule

// File: rtl/nand_front_end.sv
module nand_front_end
  import nand_fe_pkg::*;
#(
  parameter bit          WIDE_BUS    = 1'b1,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BUS_W      = WIDE_BUS ? 16 : 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_i,
  input  logic              cmd_en_i,
  input  logic              addr_en_i,
  input  logic              busy_i,
  input  logic [BUS_W-1:0]  io_i,
  input  logic [BUS_W-1:0]  rd_data_i,
  output logic [BUS_W-1:0]  io_o,
  output logic              io_oe_o,
  output logic              selected_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              addr_valid_o,
  output logic [CMD_W-1:0]  addr_o,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              proto_err_o
);
  localparam int unsigned PW = BUS_W + 3;

  logic             sel;
  logic             rise;
  logic [PW-1:0]    pl_d;
  logic             sel_d, cle_d, ale_d;
  logic [BUS_W-1:0] bus_d;

  nand_fe_select u_select (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .busy_i (busy_i),
    .sel_o  (sel)
  );

  nand_fe_strobe_sync #(.STAGES(SYNC_STAGES), .PW(PW)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (we_i),
    .payload_i ({sel, cmd_en_i, addr_en_i, io_i}),
    .rise_o    (rise),
    .payload_o (pl_d)
  );

  assign {sel_d, cle_d, ale_d, bus_d} = pl_d;

  nand_fe_capture #(.BUS_W(BUS_W)) u_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .sel_i        (sel_d),
    .cle_i        (cle_d),
    .ale_i        (ale_d),
    .bus_i        (bus_d),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_o        (cmd_o),
    .addr_valid_o (addr_valid_o),
    .addr_o       (addr_o),
    .data_valid_o (data_valid_o),
    .data_o       (data_o),
    .err_o        (proto_err_o)
  );

  nand_fe_out_drv #(.BUS_W(BUS_W)) u_out (
    .sel_i     (sel),
    .oe_ni     (oe_ni),
    .rd_data_i (rd_data_i),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o)
  );

  assign selected_o = sel;
endmodule

// File: rtl/nand_fe_checker.sv
module nand_fe_checker #(
  parameter bit          WIDE_BUS = 1'b1,
  parameter int unsigned BUS_W    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             oe_ni,
  input logic             busy_i,
  input logic [BUS_W-1:0] io_o,
  input logic             io_oe_o,
  input logic             selected_o,
  input logic             cmd_valid_o,
  input logic             addr_valid_o,
  input logic             data_valid_o,
  input logic [15:0]      data_o,
  input logic             proto_err_o
);
  p_one_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, addr_valid_o, data_valid_o, proto_err_o}));

  p_cmd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_addr_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);

  p_data_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  p_select_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni |=> selected_o);

  p_deselect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !busy_i) |=> !selected_o);

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected_o && busy_i) |=> selected_o);

  p_oe_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || !selected_o) |-> !io_oe_o);

  p_quiet_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_oe_o |-> (io_o == '0));

  if (!WIDE_BUS) begin : g_narrow
    p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_o[15:8] == 8'h00);
  end
endmodule

bind nand_front_end nand_fe_checker #(.WIDE_BUS(WIDE_BUS), .BUS_W(BUS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_ni        (ce_ni),
  .oe_ni        (oe_ni),
  .busy_i       (busy_i),
  .io_o         (io_o),
  .io_oe_o      (io_oe_o),
  .selected_o   (selected_o),
  .cmd_valid_o  (cmd_valid_o),
  .addr_valid_o (addr_valid_o),
  .data_valid_o (data_valid_o),
  .data_o       (data_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/nand_front_end_bench.sv
`timescale 1ns/1ps
module nand_front_end_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we = 1'b0, cle = 1'b0, ale = 1'b0, busy = 1'b0;
  logic [15:0] bus = '0;
  logic [15:0] rd  = 16'hC3A5;

  logic [15:0] io_w;  logic io_oe_w, sel_w, cv_w, av_w, dv_w, er_w;
  logic [7:0]  cmd_w, addr_w;  logic [15:0] data_w;
  logic [7:0]  io_n;  logic io_oe_n, sel_n, cv_n, av_n, dv_n, er_n;
  logic [7:0]  cmd_n, addr_n;  logic [15:0] data_n;

  nand_front_end #(.WIDE_BUS(1'b1)) u_nand_front_end (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_i(we),
    .cmd_en_i(cle), .addr_en_i(ale), .busy_i(busy), .io_i(bus), .rd_data_i(rd),
    .io_o(io_w), .io_oe_o(io_oe_w), .selected_o(sel_w),
    .cmd_valid_o(cv_w), .cmd_o(cmd_w), .addr_valid_o(av_w), .addr_o(addr_w),
    .data_valid_o(dv_w), .data_o(data_w), .proto_err_o(er_w));

  nand_front_end #(.WIDE_BUS(1'b0)) u_nand_front_end_x8 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_i(we),
    .cmd_en_i(cle), .addr_en_i(ale), .busy_i(busy), .io_i(bus[7:0]), .rd_data_i(rd[7:0]),
    .io_o(io_n), .io_oe_o(io_oe_n), .selected_o(sel_n),
    .cmd_valid_o(cv_n), .cmd_o(cmd_n), .addr_valid_o(av_n), .addr_o(addr_n),
    .data_valid_o(dv_n), .data_o(data_n), .proto_err_o(er_n));

  int n_vec = 0, n_bad = 0;
  int c_cmd = 0, c_addr = 0, c_data = 0, c_err = 0, c_data8 = 0;
  logic [7:0]  l_cmd, l_addr;
  logic [15:0] l_data, l_data8;

  // count high cycles of every pulse, away from the active edge
  always @(negedge clk) begin
    if (cv_w) begin c_cmd++;  l_cmd  = cmd_w;  end
    if (av_w) begin c_addr++; l_addr = addr_w; end
    if (dv_w) begin c_data++; l_data = data_w; end
    if (er_w) c_err++;
    if (dv_n) begin c_data8++; l_data8 = data_n; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    c_cmd = 0; c_addr = 0; c_data = 0; c_err = 0; c_data8 = 0;
  endtask

  task automatic do_write(input logic c, input logic a, input logic [15:0] v);
    @(negedge clk); cle = c; ale = a; bus = v;
    @(negedge clk); we = 1'b1;
    repeat (4) @(negedge clk);
    we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic select_dev();
    @(negedge clk); ce_n = 1'b0; busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R8 reset selected", {31'b0, sel_w}, 32'd0);
    check("R10 reset oe", {31'b0, io_oe_w}, 32'd0);
    check("R7 reset pulses", {28'b0, cv_w, av_w, dv_w, er_w}, 32'd0);
  endtask

  task automatic t_latency_cmd();
    select_dev();
    clear_counts();
    @(negedge clk); cle = 1'b1; ale = 1'b0; bus = 16'h0090;
    @(negedge clk); we = 1'b1;         // first edge with we high follows
    @(negedge clk); check("R11 before edge2", {31'b0, cv_w}, 32'd0);
    @(negedge clk); check("R11 before edge3", {31'b0, cv_w}, 32'd0);
    @(negedge clk); check("R11 pulse after edge3", {31'b0, cv_w}, 32'd1);
    check("R2 cmd value", {24'b0, cmd_w}, 32'h90);
    @(negedge clk); check("R7 pulse one clock", {31'b0, cv_w}, 32'd0);
    we = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 cmd count", c_cmd, 1);
  endtask

  task automatic t_addr();
    clear_counts();
    do_write(1'b0, 1'b1, 16'h003C);
    check("R3 addr count", c_addr, 1);
    check("R3 addr value", {24'b0, l_addr}, 32'h3C);
    check("R7 no cmd on addr", c_cmd, 0);
  endtask

  task automatic t_data();
    clear_counts();
    do_write(1'b0, 1'b0, 16'hBEEF);
    check("R4 data count x16", c_data, 1);
    check("R4 data value x16", {16'b0, l_data}, 32'hBEEF);
    check("R4 data count x8", c_data8, 1);
    check("R4 data value x8", {16'b0, l_data8}, 32'h00EF);
    check("R7 data pulse width", c_data + c_cmd + c_addr + c_err, 1);
  endtask

  task automatic t_upper_ignored();
    clear_counts();
    do_write(1'b1, 1'b0, 16'hA55A);
    check("R5 cmd low byte", {24'b0, l_cmd}, 32'h5A);
    do_write(1'b0, 1'b1, 16'hFF21);
    check("R5 addr low byte", {24'b0, l_addr}, 32'h21);
    check("R5 counts", c_cmd + c_addr, 2);
  endtask

  task automatic t_both_high();
    clear_counts();
    do_write(1'b1, 1'b1, 16'h0011);
    check("R6 err count", c_err, 1);
    check("R6 no cmd/addr/data", c_cmd + c_addr + c_data, 0);
    check("R6 cmd unchanged", {24'b0, cmd_w}, 32'h21 & 32'h0 | {24'b0, l_cmd});
  endtask

  task automatic t_deselected();
    @(negedge clk); ce_n = 1'b1; busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 deselect", {31'b0, sel_w}, 32'd0);
    clear_counts();
    do_write(1'b1, 1'b0, 16'h00FF);
    do_write(1'b0, 1'b0, 16'h1234);
    check("R1 no pulses when deselected", c_cmd + c_addr + c_data + c_err + c_data8, 0);
    check("R1 cmd unchanged", {24'b0, cmd_w}, 32'h5A);
  endtask

  task automatic t_busy_hold();
    select_dev();
    @(negedge clk); busy = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 held selected", {31'b0, sel_w}, 32'd1);
    clear_counts();
    do_write(1'b1, 1'b0, 16'h0070);
    check("R9 write during hold", c_cmd, 1);
    check("R9 cmd value", {24'b0, l_cmd}, 32'h70);
    @(negedge clk); busy = 1'b0;
    @(negedge clk);
    check("R9 deselect after busy", {31'b0, sel_w}, 32'd0);
  endtask

  task automatic t_output();
    select_dev();
    @(negedge clk); oe_n = 1'b0;
    #1;
    check("R10 oe on", {31'b0, io_oe_w}, 32'd1);
    check("R10 read data x16", {16'b0, io_w}, 32'hC3A5);
    check("R10 read data x8", {24'b0, io_n}, 32'hA5);
    @(negedge clk); oe_n = 1'b1;
    #1;
    check("R10 oe off", {31'b0, io_oe_w}, 32'd0);
    check("R10 bus quiet", {16'b0, io_w}, 32'd0);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 deselected no drive", {31'b0, io_oe_w}, 32'd0);
    oe_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_latency_cmd();
    t_addr();
    t_data();
    t_upper_ignored();
    t_both_high();
    t_deselected();
    t_busy_hold();
    t_output();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule